// File: doc/BRIEF.md
# Bus Beat Performance Monitor

The block sits next to one bus port and measures how busy that port is. A cycle counter and four event counters run while monitoring is switched on. Each event counter is fed by its own selector, which picks read data beats, write data beats or both from two per-cycle strobes. Software divides an event count by the cycle count to get utilisation.

All state is reached through a single-cycle register port. A write takes effect at the clock edge in which `reg_we` is high. Read data is combinational from the current address. A small two-state machine holds the global run state: `ST_IDLE` (not counting) and `ST_RUN` (counting). The transition `ST_IDLE -> ST_RUN` is taken on a control write with bit 0 set. The transition `ST_RUN -> ST_IDLE` is taken on a control write with bit 0 clear. Event counter 3 is wider than the others, by 8 bits, and is read through two slots. The usual restart is three writes in this order: a control write with bits 1 and 2 set, a count-enable write of 0x8000000F, then a control write of 1.

Top module: `bus_beat_monitor`

## Requirements
- R1: After reset, the run state is `ST_IDLE`, and every counter, enable bit, overflow flag and select code is 0. Every register reads 0.
- R2: Control register, offset 0x000. Bit 0 is the global enable, stored by the FSM and read back. Bits 1 and 2 are action bits that always read 0. All other bits read 0.
- R3: Writing 1 to control bit 1 clears the cycle counter and its overflow flag. Writing 1 to control bit 2 clears all event counters and their overflow flags. A clear wins over an increment in the same cycle.
- R4: Count-enable register, offset 0x010. Bits 0..3 enable event counters 0..3, and bit 31 enables the cycle counter. It reads back those bits only. A counter advances only in a cycle when the FSM is in `ST_RUN` and its own enable bit is set.
- R5: The cycle counter reads at offset 0x100 (CYC_W bits, default 32). It adds 1 in each enabled cycle.
- R6: Each event counter n has a select register at offset 0x1000 + 0x100*n. It holds a 3-bit code that reads back in bits 2:0. Code 5 adds 1 per read beat. Code 6 adds 1 per write beat. Code 7 adds 1 for each beat, so it adds 2 in a cycle carrying both. Any other code counts nothing.
- R7: Event counters 0..2 (EVT_W bits, default 32) read at offsets 0x110, 0x120 and 0x130.
- R8: Event counter 3 is EVT_W+8 bits wide (default 40). Its bits above the low 8 read at offset 0x140, and its low 8 bits read at offset 0x150.
- R9: A counter passing its maximum wraps modulo its width and sets its overflow flag. The flags sit in register 0x050: bits 0..3 for the event counters, bit 31 for the cycle counter. Writing 1 to a flag bit clears it. A flag set in the same cycle as its write-1-clear stays set.
- R10: Reads of unmapped offsets return 0. Writes to the counter registers, the flag bits that are not mapped, and unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| rd_beat | input | 1 | One read data beat this cycle |
| wr_beat | input | 1 | One write data beat this cycle |

## Verification
Two pairs of actions can land on the same edge. A counter increment can meet a clear written through the control register. A counter overflow can meet a write-1-clear of that same flag. The bench forces the first pair on purpose by writing a clear while both beat strobes are high. The random phase then hits both pairs many times, with small counter widths and frequent flag writes. In every cycle the read value is compared with a cycle-level bench model that applies the priorities in R3 and R9.

// File: rtl/bbm_pkg.sv
package bbm_pkg;
    localparam int NUM_EVT  = 4;
    localparam int LOW_W    = 8;
    localparam int WIDE_IDX = 3;
    localparam int CYC_BIT  = 31;

    typedef enum logic {ST_IDLE, ST_RUN} run_state_e;

    localparam logic [2:0] SEL_RD   = 3'h5;
    localparam logic [2:0] SEL_WR   = 3'h6;
    localparam logic [2:0] SEL_BOTH = 3'h7;

    localparam logic [15:0] OFS_CTRL     = 16'h0000;
    localparam logic [15:0] OFS_CNTEN    = 16'h0010;
    localparam logic [15:0] OFS_FLAG     = 16'h0050;
    localparam logic [15:0] OFS_CYC      = 16'h0100;
    localparam logic [15:0] OFS_EVT0     = 16'h0110;
    localparam logic [15:0] OFS_EVT_STEP = 16'h0010;
    localparam logic [15:0] OFS_LOW3     = 16'h0150;
    localparam logic [15:0] OFS_SEL0     = 16'h1000;
    localparam logic [15:0] OFS_SEL_STEP = 16'h0100;
endpackage

// File: rtl/bbm_ctrl.sv
module bbm_ctrl
    import bbm_pkg::*;
#(
    parameter int NE = NUM_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctrl_wr,
    input  logic          cnten_wr,
    input  logic [31:0]   wdata,
    output logic          running,
    output logic          cyc_go,
    output logic [NE-1:0] evt_go,
    output logic          clr_cyc,
    output logic          clr_evt,
    output logic [31:0]   cnten_rd
);
    run_state_e state_q, state_d;
    logic [NE:0] cnten_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state (R2)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ctrl_wr && wdata[0])  state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr && !wdata[0]) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // count-enable register (R4)
    always_ff @(posedge clk) begin
        if (!rst_n)        cnten_q <= '0;
        else if (cnten_wr) cnten_q <= {wdata[CYC_BIT], wdata[NE-1:0]};
    end

    // outputs
    always_comb begin
        running  = (state_q == ST_RUN);
        cyc_go   = running && cnten_q[NE];
        evt_go   = {NE{running}} & cnten_q[NE-1:0];
        clr_cyc  = ctrl_wr && wdata[1];
        clr_evt  = ctrl_wr && wdata[2];
        cnten_rd = {cnten_q[NE], {(31-NE){1'b0}}, cnten_q[NE-1:0]};
    end
endmodule

// File: rtl/bbm_counter.sv
module bbm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [1:0]   inc,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W:0] sum;

    always_comb begin
        sum  = {1'b0, value} + (W+1)'(inc);
        wrap = !clr && sum[W];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          value <= '0;
        else if (clr)        value <= '0;
        else if (inc != 2'd0) value <= sum[W-1:0];
    end
endmodule

// File: rtl/bbm_evsel.sv
module bbm_evsel
    import bbm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_wr,
    input  logic [2:0] wcode,
    input  logic       go,
    input  logic       rd_beat,
    input  logic       wr_beat,
    output logic [2:0] code,
    output logic [1:0] inc
);
    always_ff @(posedge clk) begin
        if (!rst_n)      code <= '0;
        else if (sel_wr) code <= wcode;
    end

    // R6: beat selection, unknown codes add nothing
    always_comb begin
        inc = 2'd0;
        if (go) begin
            case (code)
                SEL_RD:   inc = {1'b0, rd_beat};
                SEL_WR:   inc = {1'b0, wr_beat};
                SEL_BOTH: inc = {rd_beat & wr_beat, rd_beat ^ wr_beat};
                default:  inc = 2'd0;
            endcase
        end
    end
endmodule

// File: rtl/bus_beat_monitor.sv
module bus_beat_monitor
    import bbm_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 32,
    parameter int EVT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    localparam int NE     = NUM_EVT;
    localparam int WIDE_W = EVT_W + LOW_W;

    logic              ctrl_wr, cnten_wr, flag_wr;
    logic              running, cyc_go, clr_cyc, clr_evt;
    logic [NE-1:0]     evt_go, evt_wrap, sel_wr;
    logic [31:0]       cnten_rd;
    logic [CYC_W-1:0]  cyc_val;
    logic              cyc_wrap;
    logic [WIDE_W-1:0] evt_ext [NE];
    logic [2:0]        code   [NE];
    logic [NE:0]       flag_q, flag_d;

    assign ctrl_wr  = reg_we && (reg_addr == ADDR_W'(OFS_CTRL));
    assign cnten_wr = reg_we && (reg_addr == ADDR_W'(OFS_CNTEN));
    assign flag_wr  = reg_we && (reg_addr == ADDR_W'(OFS_FLAG));

    bbm_ctrl #(.NE(NE)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .cnten_wr(cnten_wr),
        .wdata(reg_wdata), .running(running), .cyc_go(cyc_go),
        .evt_go(evt_go), .clr_cyc(clr_cyc), .clr_evt(clr_evt),
        .cnten_rd(cnten_rd)
    );

    // R5: cycle counter
    bbm_counter #(.W(CYC_W)) u_cyc (
        .clk(clk), .rst_n(rst_n), .clr(clr_cyc), .inc({1'b0, cyc_go}),
        .value(cyc_val), .wrap(cyc_wrap)
    );

    for (genvar i = 0; i < NE; i++) begin : g_evt
        localparam logic [15:0] SEL_OFS = OFS_SEL0 + 16'(i) * OFS_SEL_STEP;
        logic [1:0] inc;

        assign sel_wr[i] = reg_we && (reg_addr == ADDR_W'(SEL_OFS));

        bbm_evsel u_sel (
            .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr[i]),
            .wcode(reg_wdata[2:0]), .go(evt_go[i]),
            .rd_beat(rd_beat), .wr_beat(wr_beat),
            .code(code[i]), .inc(inc)
        );

        if (i == WIDE_IDX) begin : g_wide
            // R8: widened counter
            bbm_counter #(.W(WIDE_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr_evt), .inc(inc),
                .value(evt_ext[i]), .wrap(evt_wrap[i])
            );
        end else begin : g_std
            logic [EVT_W-1:0] val;
            bbm_counter #(.W(EVT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .clr(clr_evt), .inc(inc),
                .value(val), .wrap(evt_wrap[i])
            );
            assign evt_ext[i] = WIDE_W'(val);
        end
    end

    // R9: overflow flags; order is write-1-clear, then set, then counter clear
    always_comb begin
        flag_d = flag_q;
        if (flag_wr) begin
            flag_d[NE-1:0] = flag_d[NE-1:0] & ~reg_wdata[NE-1:0];
            flag_d[NE]     = flag_d[NE] & ~reg_wdata[CYC_BIT];
        end
        flag_d = flag_d | {cyc_wrap, evt_wrap};
        if (clr_cyc) flag_d[NE] = 1'b0;
        if (clr_evt) flag_d[NE-1:0] = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    // read mux (R10: unmapped returns 0)
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_CTRL))  reg_rdata = {31'd0, running};
        if (reg_addr == ADDR_W'(OFS_CNTEN)) reg_rdata = cnten_rd;
        if (reg_addr == ADDR_W'(OFS_FLAG))
            reg_rdata = {flag_q[NE], {(31-NE){1'b0}}, flag_q[NE-1:0]};
        if (reg_addr == ADDR_W'(OFS_CYC))   reg_rdata = 32'(cyc_val);
        for (int i = 0; i < NE; i++) begin
            if (reg_addr == ADDR_W'(OFS_EVT0 + 16'(i) * OFS_EVT_STEP))
                reg_rdata = (i == WIDE_IDX) ? 32'(evt_ext[i] >> LOW_W)
                                            : 32'(evt_ext[i]);
            if (reg_addr == ADDR_W'(OFS_SEL0 + 16'(i) * OFS_SEL_STEP))
                reg_rdata = {29'd0, code[i]};
        end
        if (reg_addr == ADDR_W'(OFS_LOW3))
            reg_rdata = 32'(evt_ext[WIDE_IDX][LOW_W-1:0]);
    end
endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int ADDR_W = 16,
    parameter int CYC_W  = 32,
    parameter int WIDE_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_we,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              running,
    input logic [CYC_W-1:0]  cyc_val,
    input logic [WIDE_W-1:0] evt_ext [4],
    input logic [4:0]        flag_q
);
    logic evt_zero;
    always_comb begin
        evt_zero = 1'b1;
        for (int i = 0; i < 4; i++) if (evt_ext[i] != '0) evt_zero = 1'b0;
    end

    // R10
    unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr[3:0] != 4'd0) |-> (reg_rdata == 32'd0));

    // R2
    ctrl_action_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == '0) |-> (reg_rdata[31:1] == 31'd0));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !(reg_we && reg_addr == '0 && reg_wdata[1])) |=> $stable(cyc_val));

    // R3
    evt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && reg_wdata[2]) |=> (evt_zero && flag_q[3:0] == 4'd0));

    // R9
    cyc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[4]) |-> (cyc_val == '0));
endmodule

bind bus_beat_monitor bbm_checker #(
    .ADDR_W(ADDR_W), .CYC_W(CYC_W), .WIDE_W(WIDE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .running(running),
    .cyc_val(cyc_val), .evt_ext(evt_ext), .flag_q(flag_q)
);

// File: tb/test_bus_beat_monitor.sv
`timescale 1ns/1ps
module test_bus_beat_monitor;
    localparam int CYC_W = 10;
    localparam int EVT_W = 8;
    localparam int CYC_LIM = 1 << CYC_W;
    localparam int EVT_LIM = 1 << EVT_W;
    localparam int WIDE_LIM = 1 << (EVT_W + 8);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        rd_beat = 1'b0;
    logic        wr_beat = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // bench model
    bit          m_run;
    logic [31:0] m_cnten, m_flag;
    int          m_cyc;
    int          m_evt  [4];
    logic [2:0]  m_code [4];

    bus_beat_monitor #(.ADDR_W(16), .CYC_W(CYC_W), .EVT_W(EVT_W)) i_bus_beat_monitor (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_beat(rd_beat), .wr_beat(wr_beat)
    );

    always #4 clk = ~clk;

    function automatic int lim_of(int i);
        return (i == 3) ? WIDE_LIM : EVT_LIM;
    endfunction

    function automatic int beat_inc(logic [2:0] c, bit rb, bit wb);
        case (c)
            3'h5: return int'(rb);
            3'h6: return int'(wb);
            3'h7: return int'(rb) + int'(wb);
            default: return 0;
        endcase
    endfunction

    function automatic void model_reset();
        m_run = 0; m_cnten = '0; m_flag = '0; m_cyc = 0;
        for (int i = 0; i < 4; i++) begin m_evt[i] = 0; m_code[i] = '0; end
    endfunction

    function automatic void model_update(bit we, logic [15:0] a, logic [31:0] d, bit rb, bit wb);
        logic [31:0] f = m_flag;
        bit clrc = we && a == 16'h0 && d[1];
        bit clre = we && a == 16'h0 && d[2];
        if (we && a == 16'h50) begin
            f[3:0] = f[3:0] & ~d[3:0];
            f[31]  = f[31] & ~d[31];
        end
        if (clrc) m_cyc = 0;
        else if (m_run && m_cnten[31]) begin
            m_cyc++;
            if (m_cyc == CYC_LIM) begin m_cyc = 0; f[31] = 1'b1; end
        end
        for (int i = 0; i < 4; i++) begin
            if (clre) m_evt[i] = 0;
            else if (m_run && m_cnten[i]) begin
                m_evt[i] += beat_inc(m_code[i], rb, wb);
                if (m_evt[i] >= lim_of(i)) begin m_evt[i] -= lim_of(i); f[i] = 1'b1; end
            end
        end
        if (clrc) f[31] = 1'b0;
        if (clre) f[3:0] = 4'd0;
        m_flag = f;
        if (we) begin
            if (a == 16'h0)  m_run = d[0];
            if (a == 16'h10) m_cnten = d & 32'h8000_000F;
            for (int i = 0; i < 4; i++)
                if (a == 16'h1000 + 16'(i) * 16'h100) m_code[i] = d[2:0];
        end
    endfunction

    function automatic logic [31:0] exp_read(logic [15:0] a);
        case (a)
            16'h0000: return {31'd0, m_run};
            16'h0010: return m_cnten;
            16'h0050: return m_flag;
            16'h0100: return 32'(m_cyc);
            16'h0110: return 32'(m_evt[0]);
            16'h0120: return 32'(m_evt[1]);
            16'h0130: return 32'(m_evt[2]);
            16'h0140: return 32'(m_evt[3] >> 8);
            16'h0150: return 32'(m_evt[3] & 255);
            16'h1000: return {29'd0, m_code[0]};
            16'h1100: return {29'd0, m_code[1]};
            16'h1200: return {29'd0, m_code[2]};
            16'h1300: return {29'd0, m_code[3]};
            default:  return 32'd0;
        endcase
    endfunction

    function automatic string tag_of(logic [15:0] a);
        case (a)
            16'h0000: return "R2";
            16'h0010: return "R4";
            16'h0050: return "R9";
            16'h0100: return "R5";
            16'h0110, 16'h0120, 16'h0130: return "R7";
            16'h0140, 16'h0150: return "R8";
            16'h1000, 16'h1100, 16'h1200, 16'h1300: return "R6";
            default: return "R10";
        endcase
    endfunction

    task automatic step(bit we, logic [15:0] a, logic [31:0] d, bit rb, bit wb, bit chk, string tag);
        logic [31:0] exp;
        @(negedge clk);
        reg_we = we; reg_addr = a; reg_wdata = d; rd_beat = rb; wr_beat = wb;
        #1;
        if (chk) begin
            exp = exp_read(a);
            checks++;
            if (reg_rdata !== exp) begin
                errors++;
                $display("FAIL %s addr=%h actual=%h expected=%h", tag, a, reg_rdata, exp);
            end
        end
        @(posedge clk);
        model_update(we, a, d, rb, wb);
    endtask

    task automatic rd(logic [15:0] a, string tag);
        step(0, a, 32'd0, 0, 0, 1, tag);
    endtask

    task automatic wr(logic [15:0] a, logic [31:0] d);
        step(1, a, d, 0, 0, 0, "");
    endtask

    localparam logic [15:0] ADDRS [16] = '{16'h0000, 16'h0010, 16'h0050, 16'h0100,
        16'h0110, 16'h0120, 16'h0130, 16'h0140, 16'h0150, 16'h1000, 16'h1100,
        16'h1200, 16'h1300, 16'h0104, 16'h0060, 16'h2000};

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed;
        logic [31:0] d;
        logic [15:0] a;
        seed = $urandom(32'd20141210);
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        for (int i = 0; i < 16; i++) rd(ADDRS[i], "R1");

        // R6: select codes
        wr(16'h1000, 32'h5); wr(16'h1100, 32'h6);
        wr(16'h1200, 32'h7); wr(16'h1300, 32'hFFFF_FFF7);
        rd(16'h1000, "R6"); rd(16'h1300, "R6");

        // R4: enables readback; restart sequence
        wr(16'h0000, 32'h6); wr(16'h0010, 32'hFFFF_FFFF);
        rd(16'h0010, "R4");
        wr(16'h0000, 32'h7);
        rd(16'h0000, "R2");

        // R7 and R5: read beats then mixed beats
        for (int i = 0; i < 20; i++) step(0, 16'h0110, 0, 1, 0, 1, "R7");
        for (int i = 0; i < 20; i++) step(0, 16'h0130, 0, 1, 1, 1, "R6");
        rd(16'h0120, "R7"); rd(16'h0100, "R5");

        // R3: clear collides with increments
        step(1, 16'h0000, 32'h7, 1, 1, 1, "R3");
        step(0, 16'h0130, 0, 1, 1, 1, "R3");
        rd(16'h0100, "R3");

        // R4: counter 0 disabled
        wr(16'h0010, 32'h8000_000E);
        for (int i = 0; i < 10; i++) step(0, 16'h0110, 0, 1, 1, 1, "R4");

        // R9: overflow of counter 0, then write-1-clear
        wr(16'h0010, 32'h8000_000F);
        for (int i = 0; i < 300; i++) step(0, 16'h0050, 0, 1, 0, (i % 50) == 0, "R9");
        rd(16'h0050, "R9"); rd(16'h0110, "R9");
        wr(16'h0050, 32'h0000_0001);
        rd(16'h0050, "R9");

        // R8: wide counter split read
        for (int i = 0; i < 200; i++) step(0, 16'h0150, 0, 1, 1, 0, "R8");
        rd(16'h0140, "R8"); rd(16'h0150, "R8");

        // R10: writes to counters ignored, unmapped reads
        wr(16'h0000, 32'h0);
        wr(16'h0100, 32'h0000_FFFF); wr(16'h0140, 32'hFFFF_FFFF);
        rd(16'h0100, "R10"); rd(16'h0140, "R10");
        rd(16'h0104, "R10"); rd(16'h2000, "R10"); rd(16'h0060, "R10");

        // R6: unknown code counts nothing
        wr(16'h1100, 32'h3); wr(16'h0000, 32'h1);
        for (int i = 0; i < 10; i++) step(0, 16'h0120, 0, 1, 1, 1, "R6");

        // random phase
        for (int n = 0; n < 6000; n++) begin
            a = ADDRS[$urandom % 16];
            d = $urandom;
            if (a == 16'h0) begin
                d[0] = ($urandom % 5) != 0;
                if (($urandom % 8) != 0) d[2:1] = 2'b00;
            end
            if (a[12] && ($urandom % 2 == 0)) d[2] = 1'b1;
            step(($urandom % 6) == 0, a, d, $urandom % 2 == 1, $urandom % 2 == 1, 1, tag_of(a));
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule